// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Tags

This block sits between a serial receiver's deserializer and the host. Each received character arrives as one write strobe carrying an 8-bit byte and three error tags. The block keeps these together as an 11-bit entry in a first-in first-out store. The oldest unread entry is always shown on the host read port. When the host reads, the port moves to the next entry, and the reported tags change with it in the same step. A fill count and a data-ready flag report how much is waiting.

The host is told about waiting data through one interrupt, gated by an enable. In queue mode, the interrupt rises when the fill reaches one of four selectable thresholds. A timeout also raises it when characters sit below the threshold and the line has gone quiet. The timeout lasts four character lengths plus twelve bit times. It counts externally supplied bit-time ticks, and the character length follows a 2-bit word-length select. With queue mode off, the block holds a single character, and the interrupt follows every character.

Top module: `rx_tag_fifo`

## Requirements
- R1: The store holds DEPTH (default 128) entries of 8 data bits and 3 tag bits, and `fill_cnt` gives the number held. In queue mode, a write to a full store is accepted only if a read in the same cycle frees a slot.
- R2: `head_data` shows the data byte of the oldest unread entry. When the store is empty, `head_data` is zero, and `data_ready` is high exactly when `fill_cnt` is non-zero.
- R3: A read while data is held removes the head entry, and `head_tag` shows the tags of the next entry from the following cycle. A read of an empty store changes nothing.
- R4: In queue mode, a write to a full store with no read in the same cycle is dropped and sets the sticky `overrun` flag. `stat_rd` clears the flag. If a new overrun happens in the same cycle as `stat_rd`, the flag stays set.
- R5: When `fifo_en` differs from the mode in force, the next cycle shows an empty store and the new mode. Any write or read in that cycle is ignored.
- R6: With `fifo_en` low, a write leaves exactly the new character held (`fill_cnt`=1). If an unread character is overwritten without a read in the same cycle, `overrun` is set.
- R7: In queue mode, the interrupt threshold is set by `trig_sel`: 0 gives 1 entry, 1 gives DEPTH/4 (32), 2 gives DEPTH/2 (64) and 3 gives DEPTH-8 (120). The level interrupt is high while `fill_cnt` is at or above the threshold.
- R8: With `fifo_en` low, the interrupt is high whenever a character is held.
- R9: In queue mode, while data is held, a counter advances on each `bit_tick`. Any write or read strobe restarts it. After 4*(7+`wlen_sel`)+12 ticks, the timeout sets and holds the interrupt high until the next write, read or emptying.
- R10: With `irq_en` low, `irq` is low.
- R11: After reset the store is empty, `overrun` and `irq` are low, and the single-character mode is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Received-character write strobe |
| wr_data | input | 8 | Received data byte |
| wr_tag | input | 3 | Error tags of the received character |
| rd_en | input | 1 | Host read of the head entry |
| stat_rd | input | 1 | Host status read, clears overrun |
| fifo_en | input | 1 | Queue mode enable |
| irq_en | input | 1 | Data-ready interrupt enable |
| trig_sel | input | 2 | Threshold select |
| wlen_sel | input | 2 | Word length select (5 to 8 data bits) |
| bit_tick | input | 1 | One pulse per serial bit time |
| head_data | output | 8 | Data byte of the oldest entry |
| head_tag | output | 3 | Error tags of the oldest entry |
| fill_cnt | output | 8 | Entries held |
| data_ready | output | 1 | At least one entry held |
| overrun | output | 1 | Sticky dropped-character flag |
| irq | output | 1 | Data-ready interrupt |

## Verification
Two pairs of events can land in the same cycle. The first is a character write and a host read while the store is full, where the read must free the slot so that the write is taken rather than flagged. The second is a status read in the cycle that an overrun occurs, where the flag must stay set. The bench fills the store to DEPTH, then issues a read together with a write, and next a write together with `stat_rd`. A behavioural queue model predicts fill, head, tags and flag for every clock, and the bench compares them. A long random phase adds further read-write collisions and mode changes that coincide with strobes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W = 8;
    localparam int TAG_W  = 3;
    localparam int TMO_W  = 6;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;

    // threshold in entries for a given select code
    function automatic int unsigned trig_level(input logic [1:0] sel,
                                               input int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 8;
        endcase
    endfunction

    // four characters (start + data + stop) plus twelve bit times
    function automatic logic [TMO_W-1:0] tmo_limit(input logic [1:0] wlen);
        int unsigned char_bits;
        char_bits = 7 + int'(wlen);
        return TMO_W'(4 * char_bits + 12);
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_mode,
    input  logic          flush,
    input  logic          wr_en,
    input  rxq_entry_t    wr_entry,
    input  logic          rd_en,
    input  logic          stat_rd,
    output rxq_entry_t    head,
    output logic [CW-1:0] count,
    output logic          overrun
);

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_inc, rd_ptr_inc, wsel;
    logic          is_full, pop_ok, push_ok, ovr_set;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_ptr_inc = wr_ptr + AW'(1);
            assign rd_ptr_inc = rd_ptr + AW'(1);
        end else begin : g_wrap
            assign wr_ptr_inc = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            assign rd_ptr_inc = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
        end
    endgenerate

    assign is_full = (count == CW'(DEPTH));
    assign pop_ok  = !flush && rd_en && (count != '0);

    always_comb begin
        if (fifo_mode) begin
            push_ok = !flush && wr_en && (!is_full || pop_ok);
            ovr_set = !flush && wr_en && is_full && !pop_ok;
            wsel    = wr_ptr;
        end else begin
            push_ok = !flush && wr_en;
            ovr_set = !flush && wr_en && (count != '0) && !rd_en;
            wsel    = rd_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wsel] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (fifo_mode) begin
            if (push_ok) wr_ptr <= wr_ptr_inc;
            if (pop_ok)  rd_ptr <= rd_ptr_inc;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end else begin
            if (push_ok)     count <= CW'(1);
            else if (pop_ok) count <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          overrun <= 1'b0;
        else if (ovr_set) overrun <= 1'b1;
        else if (stat_rd) overrun <= 1'b0;
    end

    assign head = (count != '0) ? mem[rd_ptr] : '0;

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       restart,
    input  logic       bit_tick,
    input  logic [1:0] wlen_sel,
    output logic       tmo
);

    logic [TMO_W-1:0] cnt, lim, cnt_inc;

    assign lim     = tmo_limit(wlen_sel);
    assign cnt_inc = cnt + TMO_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !active || restart) begin
            cnt <= '0;
            tmo <= 1'b0;
        end else if (bit_tick && !tmo) begin
            cnt <= cnt_inc;
            if (cnt_inc >= lim) tmo <= 1'b1;
        end
    end

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
    import rxq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          fifo_mode,
    input  logic          irq_en,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] count,
    input  logic          tmo,
    output logic          irq
);

    logic [CW-1:0] lvl;
    logic          cause;

    assign lvl = CW'(trig_level(trig_sel, DEPTH));

    always_comb begin
        if (fifo_mode) cause = (count >= lvl) || tmo;
        else           cause = (count != '0);
        irq = irq_en && cause;
    end

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              rd_en,
    input  logic              stat_rd,
    input  logic              fifo_en,
    input  logic              irq_en,
    input  logic [1:0]        trig_sel,
    input  logic [1:0]        wlen_sel,
    input  logic              bit_tick,
    output logic [DATA_W-1:0] head_data,
    output logic [TAG_W-1:0]  head_tag,
    output logic [CW-1:0]     fill_cnt,
    output logic              data_ready,
    output logic              overrun,
    output logic              irq
);

    logic       mode_q, flush, tmo;
    rxq_entry_t in_entry, head;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= fifo_en;
    end

    assign flush    = (fifo_en != mode_q);
    assign in_entry = '{tag: wr_tag, data: wr_data};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .fifo_mode(mode_q),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_entry (in_entry),
        .rd_en    (rd_en),
        .stat_rd  (stat_rd),
        .head     (head),
        .count    (fill_cnt),
        .overrun  (overrun)
    );

    rxq_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .active  (mode_q && !flush && (fill_cnt != '0)),
        .restart (wr_en || rd_en),
        .bit_tick(bit_tick),
        .wlen_sel(wlen_sel),
        .tmo     (tmo)
    );

    rxq_irq #(.DEPTH(DEPTH)) u_irq (
        .fifo_mode(mode_q),
        .irq_en   (irq_en),
        .trig_sel (trig_sel),
        .count    (fill_cnt),
        .tmo      (tmo),
        .irq      (irq)
    );

    assign head_data  = head.data;
    assign head_tag   = head.tag;
    assign data_ready = (fill_cnt != '0);

endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_en,
    input logic          mode_q,
    input logic          wr_en,
    input logic          rd_en,
    input logic          stat_rd,
    input logic          irq_en,
    input logic [CW-1:0] fill_cnt,
    input logic [7:0]    head_data,
    input logic [2:0]    head_tag,
    input logic          overrun,
    input logic          irq
);

    // R1
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= CW'(DEPTH));

    // R2
    empty_head_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == '0) |-> (head_data == 8'd0 && head_tag == 3'd0));

    // R3
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q && fifo_en == mode_q && rd_en && !wr_en && fill_cnt != '0)
        |=> (fill_cnt == $past(fill_cnt) - CW'(1)));

    // R4
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q && fifo_en && wr_en && !rd_en && fill_cnt == CW'(DEPTH))
        |=> (overrun && fill_cnt == CW'(DEPTH)));

    // R4
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun && !stat_rd) |=> overrun);

    // R5
    mode_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en != mode_q) |=> (fill_cnt == '0));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fifo_en  (fifo_en),
    .mode_q   (mode_q),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .stat_rd  (stat_rd),
    .irq_en   (irq_en),
    .fill_cnt (fill_cnt),
    .head_data(head_data),
    .head_tag (head_tag),
    .overrun  (overrun),
    .irq      (irq)
);

// File: tb/rx_tag_fifo_bench.sv
module rx_tag_fifo_bench;

    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 0, rd_en = 0, stat_rd = 0, fifo_en = 0, irq_en = 0, bit_tick = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] wr_tag = 0;
    logic [1:0] trig_sel = 0, wlen_sel = 0;
    logic [7:0] head_data;
    logic [2:0] head_tag;
    logic [7:0] fill_cnt;
    logic       data_ready, overrun, irq;

    always #4 clk = ~clk;

    rx_tag_fifo #(.DEPTH(DEPTH)) u_rx_tag_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
        .rd_en(rd_en), .stat_rd(stat_rd), .fifo_en(fifo_en), .irq_en(irq_en),
        .trig_sel(trig_sel), .wlen_sel(wlen_sel), .bit_tick(bit_tick),
        .head_data(head_data), .head_tag(head_tag), .fill_cnt(fill_cnt),
        .data_ready(data_ready), .overrun(overrun), .irq(irq)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // behavioural reference model
    logic [10:0] q[$];
    bit m_mode, m_ovr, m_tmo, live;
    int m_cnt;

    function automatic int thresh(input logic [1:0] s);
        int r;
        case (s)
            2'd0: r = 1;
            2'd1: r = 32;
            2'd2: r = 64;
            default: r = 120;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        int  sz, lim;
        bit  pop, setov, clr;
        if (rst) begin
            q.delete();
            m_mode = 0; m_ovr = 0; m_tmo = 0; m_cnt = 0;
        end else begin
            sz    = q.size();
            pop   = rd_en && sz > 0;
            setov = 0;
            clr   = (fifo_en != m_mode) || wr_en || rd_en || sz == 0 || !m_mode;
            lim   = 4 * (7 + int'(wlen_sel)) + 12;
            if (fifo_en != m_mode) begin
                q.delete();
                m_mode = fifo_en;
            end else if (m_mode) begin
                if (pop) void'(q.pop_front());
                if (wr_en) begin
                    if (sz < DEPTH || pop) q.push_back({wr_tag, wr_data});
                    else setov = 1;
                end
            end else begin
                if (wr_en) begin
                    if (sz != 0 && !rd_en) setov = 1;
                    q.delete();
                    q.push_back({wr_tag, wr_data});
                end else if (pop) q.delete();
            end
            if (setov)        m_ovr = 1;
            else if (stat_rd) m_ovr = 0;
            if (clr) begin
                m_cnt = 0; m_tmo = 0;
            end else if (bit_tick && !m_tmo) begin
                m_cnt++;
                if (m_cnt >= lim) m_tmo = 1;
            end
        end
        live = !rst;
    end

    always @(negedge clk) begin
        int    sz, e_irq;
        string ireq;
        if (live && !rst && !done) begin
            sz = q.size();
            check("R1 fill", int'(fill_cnt), sz);
            check("R2 head data", int'(head_data), sz ? int'(q[0][7:0]) : 0);
            check("R2 ready", int'(data_ready), int'(sz != 0));
            check("R3 head tag", int'(head_tag), sz ? int'(q[0][10:8]) : 0);
            check("R4 overrun", int'(overrun), int'(m_ovr));
            if (!m_mode) e_irq = (sz != 0);
            else e_irq = (sz >= thresh(trig_sel)) || m_tmo;
            e_irq = e_irq && irq_en;
            if (!irq_en) ireq = "R10 irq gate";
            else if (!m_mode) ireq = "R8 irq";
            else if (m_tmo && sz < thresh(trig_sel)) ireq = "R9 timeout irq";
            else ireq = "R7 level irq";
            check(ireq, int'(irq), e_irq);
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
        wr_en = 0; rd_en = 0; stat_rd = 0; bit_tick = 0;
    endtask

    task automatic wr(input int d, input int t);
        wr_en = 1; wr_data = 8'(d); wr_tag = 3'(t);
        cyc();
    endtask

    task automatic rd();
        rd_en = 1;
        cyc();
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (2) @(posedge clk);
        #3;
        // R11 reset state
        check("R11 reset fill", int'(fill_cnt), 0);
        check("R11 reset overrun", int'(overrun), 0);
        check("R11 reset irq", int'(irq), 0);
        @(posedge clk); #2;
        rst = 0;
        irq_en = 1;

        // R6 / R8 single holding register
        wr(8'h41, 1);
        wr(8'h42, 2);            // overwrite -> overrun
        stat_rd = 1; cyc();
        rd();
        rd();                    // empty read ignored
        wr(8'h43, 4);
        wr_en = 1; rd_en = 1; wr_data = 8'h44; wr_tag = 5; cyc();  // no overrun
        rd();

        // R5 switch to queue mode with a write in the flush cycle
        fifo_en = 1; wr_en = 1; wr_data = 8'h99; cyc();
        trig_sel = 0;
        for (int i = 0; i < 5; i++) wr(i + 16, i);
        rd(); rd();
        wr_en = 1; rd_en = 1; wr_data = 8'h77; wr_tag = 7; cyc();
        for (int i = 0; i < 5; i++) rd();

        // R1 / R4 / R7 fill beyond capacity
        for (int i = 0; i < DEPTH + 2; i++) begin
            trig_sel = 2'(i / 40);
            wr(i, i % 8);
        end
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            cyc();
        end
        wr_en = 1; rd_en = 1; wr_data = 8'hA5; wr_tag = 6; cyc();   // full, read frees slot
        stat_rd = 1; cyc();                                          // clear
        wr_en = 1; stat_rd = 1; wr_data = 8'h5A; cyc();              // set wins over clear
        stat_rd = 1; cyc();
        for (int i = 0; i < DEPTH + 1; i++) rd();

        // R9 timeout for each word length
        trig_sel = 3;
        for (int w = 0; w < 4; w++) begin
            wlen_sel = 2'(w);
            wr(w, 1); wr(w + 1, 2);
            for (int k = 0; k < 30; k++) begin bit_tick = 1; cyc(); cyc(); end
            rd();
            for (int k = 0; k < 60; k++) begin bit_tick = 1; cyc(); end
            rd(); rd();
            for (int k = 0; k < 5; k++) begin bit_tick = 1; cyc(); end
        end

        // R10 gating with data held
        irq_en = 0;
        wr(1, 1); cyc(); rd();
        irq_en = 1;

        // R5 mode change with data held
        for (int i = 0; i < 10; i++) wr(i, 3);
        fifo_en = 0; rd_en = 1; cyc();
        cyc();

        // mixed random traffic
        for (int i = 0; i < 6000; i++) begin
            wr_en    = ($urandom % 100) < 55;
            rd_en    = ($urandom % 100) < 40;
            stat_rd  = ($urandom % 100) < 5;
            bit_tick = ($urandom % 100) < 60;
            wr_data  = 8'($urandom);
            wr_tag   = 3'($urandom);
            if ($urandom % 50 == 0) irq_en = ~irq_en;
            if ($urandom % 80 == 0) trig_sel = 2'($urandom);
            if ($urandom % 900 == 0) fifo_en = ~fifo_en;
            if ($urandom % 200 == 0) wlen_sel = 2'($urandom);
            if (i > 4000 && i < 4300) rd_en = 0;
            cyc();
        end
        cyc(); cyc();
        finish_up();
    end

endmodule